// File: doc/BRIEF.md
# Dual-Channel DMA Burst Arbiter

This block decides which of two DMA engines drives a shared 32-bit bus-master port, and shapes every burst that engine issues. The receive engine writes frames from its FIFO into memory. The transmit engine reads descriptors and data from memory into its FIFO. Each engine is loaded with a word address and a word count. The arbiter then splits that transfer into bursts, advances the address for every word the target accepts, and drops the engine's busy flag once the last word has gone.

Each engine has a count byte. Its top bit arms a tenure counter, and its low seven bits give the tenure length in groups of four data phases. When the counter runs out, the owner gives up the bus only if the other engine has work. If the other engine is idle, the burst keeps going. The counter is therefore an internal fairness control and not a limit on burst length. Two mode bits pull burst edges onto cache lines. One ends a read burst that began mid-line at the end of that line. The other moves a write hand-over forward to the next line end. A target disconnect or retry ends the burst, and the next tenure resumes at the first word the target did not take.

Top module: `dma_burst_arb`

## Requirements
- R1: While reset is applied, and until the first load after it, both grants, `bm_valid`, both take strobes and both busy flags are 0.
- R2: A load pulse on an idle channel (busy 0) captures the address and the length. The channel is busy while words remain. A load pulse on a busy channel is ignored and does not change its address or its remaining count.
- R3: `bm_valid` is 1 only during a grant, and only while the owner's FIFO is ready: the receive FIFO not empty for a write (`bm_write`=1), the transmit FIFO not full for a read (`bm_write`=0). A word is taken, and the owner's take strobe pulses, in each cycle with `bm_valid` and `tgt_ready` both 1.
- R4: When a channel's count byte has bit 7 set, its tenure limit is bits 6:0 times four words. Once that many words have been taken in the tenure and the other channel is busy, the burst ends after the word that reached the limit.
- R5: When the limit is reached but the other channel is idle, or when bit 7 is 0, the burst continues until some other end condition occurs.
- R6: Only one grant is active at a time. If one channel is busy, that channel is granted. If both are busy, grants alternate, and the receive channel goes first after reset.
- R7: `tgt_stop` together with `tgt_ready` takes the current word and ends the burst. `tgt_stop` without `tgt_ready` ends the burst without taking the word.
- R8: Every word of a load appears exactly once, at consecutive addresses. A burst that follows an early end starts at the first word not taken. Busy drops in the cycle after the last word is taken.
- R9: With `cfg_wr_align`=1, a write hand-over due under R4 is held back until the taken word is the last word of a cache line, meaning that address+1 is a multiple of `cfg_line_words`.
- R10: With `cfg_rd_align`=1, a read burst whose first address is not on a line boundary ends after the word that completes that line.
- R11: If the owner's FIFO is not ready during a grant, the burst ends in that cycle.
- R12: Between the end of one grant and the start of the next there is at least one cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ld | input | 1 | Load pulse, receive channel |
| rx_ld_addr | input | AW | Start word address, receive |
| rx_ld_len | input | LW | Word count, receive |
| rx_empty | input | 1 | Receive FIFO has no word to write |
| rx_busy | output | 1 | Receive words remain |
| rx_take | output | 1 | Receive word accepted by target |
| tx_ld | input | 1 | Load pulse, transmit channel |
| tx_ld_addr | input | AW | Start word address, transmit |
| tx_ld_len | input | LW | Word count, transmit |
| tx_full | input | 1 | Transmit FIFO has no room |
| tx_busy | output | 1 | Transmit words remain |
| tx_put | output | 1 | Transmit word accepted by target |
| cfg_rx_cnt | input | 8 | Receive count byte: bit 7 arm, bits 6:0 groups of four |
| cfg_tx_cnt | input | 8 | Transmit count byte, same layout |
| cfg_rd_align | input | 1 | Line-align read burst starts |
| cfg_wr_align | input | 1 | Line-align write hand-overs |
| cfg_line_words | input | 6 | Cache line in words: 4, 8, 16 or 32 |
| gnt_rx | output | 1 | Receive channel owns the bus |
| gnt_tx | output | 1 | Transmit channel owns the bus |
| bm_valid | output | 1 | Data phase offered |
| bm_write | output | 1 | 1 for a memory write (receive), 0 for a read |
| bm_addr | output | AW | Word address of the current phase |
| tgt_ready | input | 1 | Target accepts the phase |
| tgt_stop | input | 1 | Target ends the burst |

## Verification
The hardest case to reach is a write hand-over that reaches its tenure limit while the transmit channel is waiting, at an address in the middle of a cache line. A random run rarely lines up all three conditions. A directed case starts the receive transfer two words into a line and loads the transmit channel one cycle later, so the hand-over must wait two words past the limit. Random traffic with short limits, line sizes that change, random disconnects and FIFO stalls runs alongside a cycle-level reference model of both channels.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    BST_IDLE = 1'b0,
    BST_RUN  = 1'b1
  } bst_e;

  localparam int unsigned CH_N  = 2;
  localparam logic        CH_RX = 1'b0;
  localparam logic        CH_TX = 1'b1;

  // count byte: arm bit plus tenure length in groups of four words
  typedef struct packed {
    logic       arm;
    logic [6:0] quads;
  } cnt_cfg_t;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[1];

endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
  parameter int AW = 30,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          last_word
);

  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          upd;

  assign busy      = (rem_q != '0);
  assign last_word = (rem_q == L_ONE);
  assign addr      = addr_q;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    upd    = 1'b0;
    if (ld && !busy) begin
      addr_d = ld_addr;
      rem_d  = ld_len;
      upd    = 1'b1;
    end else if (adv) begin
      addr_d = addr_q + A_ONE;
      rem_d  = rem_q - L_ONE;
      upd    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (upd) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend,
  input  logic       commit,
  output logic       pick,
  output logic       any
);

  logic last_q;

  assign any  = |pend;
  assign pick = (pend[CH_RX] && (!pend[CH_TX] || (last_q == CH_TX))) ? CH_RX : CH_TX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= CH_TX;
    end else if (commit) begin
      last_q <= pick;
    end
  end

endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl
  import dma_arb_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pend,
  input  logic                pick,
  input  logic                any,
  input  logic [1:0]          blk,
  input  logic [1:0]          last_word,
  input  logic [1:0][AW-1:0]  ch_addr,
  input  cnt_cfg_t [1:0]      cnt_cfg,
  input  logic                rd_align,
  input  logic                wr_align,
  input  logic [5:0]          line_words,
  input  logic                tgt_ready,
  input  logic                tgt_stop,
  output logic [1:0]          gnt,
  output logic                valid,
  output logic                write,
  output logic                acc,
  output logic                own,
  output logic                commit
);

  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [BW-1:0] B_ONE = BW'(1);

  bst_e          state_q, state_d;
  logic          own_q, own_d;
  logic [BW-1:0] beats_q, beats_d, beats_inc;
  logic          unal_q, unal_d;

  logic [AW-1:0] line_mask;
  logic [AW-1:0] own_addr;
  logic [BW-1:0] lim;
  logic          run, is_wr, lim_hit, nxt_al, hand, rd_cut, end_burst;

  assign line_mask = AW'(line_words) - A_ONE;
  assign run       = (state_q == BST_RUN);
  assign own       = own_q;
  assign own_addr  = ch_addr[own_q];
  assign is_wr     = (own_q == CH_RX);
  assign write     = run && is_wr;
  assign valid     = run && !blk[own_q];
  assign acc       = valid && tgt_ready;

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_gnt
      assign gnt[c] = run && (own_q == c[0]);
    end
  endgenerate

  // tenure counting and the end-of-burst terms
  assign beats_inc = (beats_q == '1) ? beats_q : beats_q + B_ONE;
  assign lim       = BW'({cnt_cfg[own_q].quads, 2'b00});
  assign lim_hit   = cnt_cfg[own_q].arm && (beats_inc >= lim);
  assign nxt_al    = (((own_addr + A_ONE) & line_mask) == '0);
  assign hand      = lim_hit && pend[~own_q] && (!is_wr || !wr_align || nxt_al);
  assign rd_cut    = !is_wr && rd_align && unal_q && nxt_al;
  assign end_burst = run && (blk[own_q] || (valid && tgt_stop) ||
                             (acc && (last_word[own_q] || hand || rd_cut)));

  always_comb begin
    state_d = state_q;
    own_d   = own_q;
    beats_d = beats_q;
    unal_d  = unal_q;
    commit  = 1'b0;
    if (!run) begin
      if (any) begin
        state_d = BST_RUN;
        own_d   = pick;
        beats_d = '0;
        unal_d  = ((ch_addr[pick] & line_mask) != '0);
        commit  = 1'b1;
      end
    end else begin
      if (acc) begin
        beats_d = beats_inc;
      end
      if (end_burst) begin
        state_d = BST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BST_IDLE;
      own_q   <= CH_RX;
      beats_q <= '0;
      unal_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
      beats_q <= beats_d;
      unal_q  <= unal_d;
    end
  end

endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb
  import dma_arb_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 16,
  parameter int BW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ld,
  input  logic [AW-1:0] rx_ld_addr,
  input  logic [LW-1:0] rx_ld_len,
  input  logic          rx_empty,
  output logic          rx_busy,
  output logic          rx_take,
  input  logic          tx_ld,
  input  logic [AW-1:0] tx_ld_addr,
  input  logic [LW-1:0] tx_ld_len,
  input  logic          tx_full,
  output logic          tx_busy,
  output logic          tx_put,
  input  logic [7:0]    cfg_rx_cnt,
  input  logic [7:0]    cfg_tx_cnt,
  input  logic          cfg_rd_align,
  input  logic          cfg_wr_align,
  input  logic [5:0]    cfg_line_words,
  output logic          gnt_rx,
  output logic          gnt_tx,
  output logic          bm_valid,
  output logic          bm_write,
  output logic [AW-1:0] bm_addr,
  input  logic          tgt_ready,
  input  logic          tgt_stop
);

  logic                core_rst_n;
  logic [1:0]          ld_v, busy_v, last_v, adv_v, blk_v, gnt_v;
  logic [1:0][AW-1:0]  ld_addr_v, addr_v;
  logic [1:0][LW-1:0]  ld_len_v;
  cnt_cfg_t [1:0]      cnt_v;
  logic                pick, any, commit, acc, own;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (core_rst_n)
  );

  assign ld_v[CH_RX]      = rx_ld;
  assign ld_v[CH_TX]      = tx_ld;
  assign ld_addr_v[CH_RX] = rx_ld_addr;
  assign ld_addr_v[CH_TX] = tx_ld_addr;
  assign ld_len_v[CH_RX]  = rx_ld_len;
  assign ld_len_v[CH_TX]  = tx_ld_len;
  assign blk_v[CH_RX]     = rx_empty;
  assign blk_v[CH_TX]     = tx_full;
  assign cnt_v[CH_RX]     = cfg_rx_cnt;
  assign cnt_v[CH_TX]     = cfg_tx_cnt;

  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      assign adv_v[c] = acc && (own == c[0]);
      dma_chan_ctx #(.AW(AW), .LW(LW)) u_ctx (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .ld        (ld_v[c]),
        .ld_addr   (ld_addr_v[c]),
        .ld_len    (ld_len_v[c]),
        .adv       (adv_v[c]),
        .addr      (addr_v[c]),
        .busy      (busy_v[c]),
        .last_word (last_v[c])
      );
    end
  endgenerate

  dma_rr_pick u_pick (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .pend   (busy_v),
    .commit (commit),
    .pick   (pick),
    .any    (any)
  );

  dma_burst_ctl #(.AW(AW), .BW(BW)) u_ctl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .pend       (busy_v),
    .pick       (pick),
    .any        (any),
    .blk        (blk_v),
    .last_word  (last_v),
    .ch_addr    (addr_v),
    .cnt_cfg    (cnt_v),
    .rd_align   (cfg_rd_align),
    .wr_align   (cfg_wr_align),
    .line_words (cfg_line_words),
    .tgt_ready  (tgt_ready),
    .tgt_stop   (tgt_stop),
    .gnt        (gnt_v),
    .valid      (bm_valid),
    .write      (bm_write),
    .acc        (acc),
    .own        (own),
    .commit     (commit)
  );

  assign gnt_rx  = gnt_v[CH_RX];
  assign gnt_tx  = gnt_v[CH_TX];
  assign bm_addr = addr_v[own];
  assign rx_busy = busy_v[CH_RX];
  assign tx_busy = busy_v[CH_TX];
  assign rx_take = adv_v[CH_RX];
  assign tx_put  = adv_v[CH_TX];

endmodule

// File: rtl/dma_burst_arb_chk.sv
module dma_burst_arb_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt_rx,
  input logic          gnt_tx,
  input logic          bm_valid,
  input logic          bm_write,
  input logic [AW-1:0] bm_addr,
  input logic          tgt_ready,
  input logic          tgt_stop,
  input logic          rx_take,
  input logic          rx_empty,
  input logic          rx_busy
);

  localparam logic [AW-1:0] A_ONE = AW'(1);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_rx && gnt_tx)); // R6

  AST_GAP_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_rx) |-> !gnt_tx); // R12

  AST_GAP_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_tx) |-> !gnt_rx); // R12

  AST_STOP_ENDS_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && tgt_stop) |=> !(gnt_rx || gnt_tx)); // R7

  AST_RX_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && tgt_ready && gnt_rx) |=>
      (!(gnt_rx && bm_valid) || (bm_addr == $past(bm_addr) + A_ONE))); // R8

  AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_valid && !tgt_ready && !tgt_stop) |=>
      (!bm_valid || (bm_addr == $past(bm_addr)))); // R8

  AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> (bm_write && !rx_empty)); // R3

  AST_BUSY_DROP_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy) |-> $past(rx_take)); // R8

endmodule

bind dma_burst_arb dma_burst_arb_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .gnt_rx    (gnt_rx),
  .gnt_tx    (gnt_tx),
  .bm_valid  (bm_valid),
  .bm_write  (bm_write),
  .bm_addr   (bm_addr),
  .tgt_ready (tgt_ready),
  .tgt_stop  (tgt_stop),
  .rx_take   (rx_take),
  .rx_empty  (rx_empty),
  .rx_busy   (rx_busy)
);

// File: tb/dma_burst_arb_test.sv
`timescale 1ns/1ps
module dma_burst_arb_test;

  localparam int AW = 30;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_ld, tx_ld, rx_empty, tx_full;
  logic [AW-1:0] rx_ld_addr, tx_ld_addr;
  logic [LW-1:0] rx_ld_len, tx_ld_len;
  logic [7:0]    cfg_rx_cnt, cfg_tx_cnt;
  logic          cfg_rd_align, cfg_wr_align;
  logic [5:0]    cfg_line_words;
  logic          tgt_ready, tgt_stop;
  logic          rx_busy, tx_busy, rx_take, tx_put, gnt_rx, gnt_tx, bm_valid, bm_write;
  logic [AW-1:0] bm_addr;

  always #2 clk = ~clk;

  dma_burst_arb uut (
    .clk(clk), .rst_n(rst_n),
    .rx_ld(rx_ld), .rx_ld_addr(rx_ld_addr), .rx_ld_len(rx_ld_len), .rx_empty(rx_empty),
    .rx_busy(rx_busy), .rx_take(rx_take),
    .tx_ld(tx_ld), .tx_ld_addr(tx_ld_addr), .tx_ld_len(tx_ld_len), .tx_full(tx_full),
    .tx_busy(tx_busy), .tx_put(tx_put),
    .cfg_rx_cnt(cfg_rx_cnt), .cfg_tx_cnt(cfg_tx_cnt), .cfg_rd_align(cfg_rd_align),
    .cfg_wr_align(cfg_wr_align), .cfg_line_words(cfg_line_words),
    .gnt_rx(gnt_rx), .gnt_tx(gnt_tx), .bm_valid(bm_valid), .bm_write(bm_write),
    .bm_addr(bm_addr), .tgt_ready(tgt_ready), .tgt_stop(tgt_stop)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit            model_on = 1'b0;
  bit            m_run, m_own, m_last, m_unal;
  int            m_beats;
  logic [AW-1:0] m_addr [2];
  int            m_rem  [2];

  // burst monitor
  int            blen [64];
  int            bown [64];
  longint        bstart [64];
  int            nb = 0;
  int            cur_len, rx_takes_total;
  longint        cur_start;
  bit            prev_g, prev_own;

  function automatic logic [AW-1:0] lmask(input logic [5:0] lw);
    return AW'(lw) - AW'(1);
  endfunction

  function automatic bit tenure_hit(input logic [7:0] cb, input int beats_after);
    return cb[7] && (beats_after >= int'(cb[6:0]) * 4);
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      bit blk, e_valid, acc, stp, rdy, endb;
      bit g_now;
      logic [7:0] cb;
      logic [AW-1:0] msk;
      int binc;
      msk = lmask(cfg_line_words);
      rdy = tgt_ready;
      stp = tgt_stop;
      blk = m_own ? tx_full : rx_empty;
      e_valid = m_run && !blk;
      acc = e_valid && rdy;
      chk_eq("R6", "gnt_rx", gnt_rx, m_run && !m_own);
      chk_eq("R6", "gnt_tx", gnt_tx, m_run && m_own);
      chk_eq("R3", "bm_valid", bm_valid, e_valid);
      chk_eq("R3", "rx_take", rx_take, acc && !m_own);
      chk_eq("R3", "tx_put", tx_put, acc && m_own);
      if (e_valid) begin
        chk_eq("R3", "bm_write", bm_write, !m_own);
        chk_eq("R8", "bm_addr", bm_addr, m_addr[m_own]);
      end
      chk_eq("R2", "rx_busy", rx_busy, m_rem[0] != 0);
      chk_eq("R2", "tx_busy", tx_busy, m_rem[1] != 0);

      // burst monitor on observed outputs
      g_now = gnt_rx || gnt_tx;
      if (g_now && prev_g) chk_eq("R12", "owner kept in tenure", gnt_tx, prev_own);
      if (g_now && !prev_g) begin cur_len = 0; cur_start = -1; end
      if (rx_take || tx_put) begin
        if (cur_start < 0) cur_start = bm_addr;
        cur_len++;
      end
      if (rx_take) rx_takes_total++;
      if (!g_now && prev_g && nb < 64) begin
        blen[nb] = cur_len; bown[nb] = prev_own; bstart[nb] = cur_start; nb++;
      end
      prev_g = g_now;
      if (g_now) prev_own = gnt_tx;

      // advance the model by one clock
      if (!m_run) begin
        if (m_rem[0] != 0 || m_rem[1] != 0) begin
          bit p;
          p = (m_rem[0] != 0 && (m_rem[1] == 0 || m_last)) ? 1'b0 : 1'b1;
          m_run = 1'b1; m_own = p; m_last = p; m_beats = 0;
          m_unal = ((m_addr[p] & msk) != '0);
        end
      end else begin
        bit nal, hand, rcut;
        cb = m_own ? cfg_tx_cnt : cfg_rx_cnt;
        binc = (m_beats >= 511) ? 511 : m_beats + 1;
        nal = (((m_addr[m_own] + AW'(1)) & msk) == '0);
        hand = tenure_hit(cb, binc) && (m_rem[!m_own] != 0) &&
               (m_own || !cfg_wr_align || nal);
        rcut = m_own && cfg_rd_align && m_unal && nal;
        endb = blk || (e_valid && stp) || (acc && (m_rem[m_own] == 1 || hand || rcut));
        if (acc) m_beats = binc;
        if (endb) m_run = 1'b0;
      end
      for (int c = 0; c < 2; c++) begin
        bit ld_c;
        ld_c = c ? tx_ld : rx_ld;
        if (ld_c && m_rem[c] == 0) begin
          m_addr[c] = c ? tx_ld_addr : rx_ld_addr;
          m_rem[c]  = c ? int'(tx_ld_len) : int'(rx_ld_len);
        end else if (acc && (m_own == c[0])) begin
          m_addr[c] = m_addr[c] + AW'(1);
          m_rem[c]  = m_rem[c] - 1;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet_bus();
    tgt_ready = 1'b1; tgt_stop = 1'b0; rx_empty = 1'b0; tx_full = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      tick();
      if (!rx_busy && !tx_busy && !gnt_rx && !gnt_tx) break;
    end
    tick(); tick();
  endtask

  task automatic load_one(input bit ch, input int a, input int n);
    tick();
    if (ch) begin tx_ld = 1'b1; tx_ld_addr = AW'(a); tx_ld_len = LW'(n); end
    else    begin rx_ld = 1'b1; rx_ld_addr = AW'(a); rx_ld_len = LW'(n); end
    tick();
    rx_ld = 1'b0; tx_ld = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd24117));
    rst_n = 1'b0;
    rx_ld = 1'b0; tx_ld = 1'b0; rx_ld_addr = '0; tx_ld_addr = '0;
    rx_ld_len = '0; tx_ld_len = '0;
    cfg_rx_cnt = 8'h00; cfg_tx_cnt = 8'h00; cfg_rd_align = 1'b0; cfg_wr_align = 1'b0;
    cfg_line_words = 6'd8;
    quiet_bus();
    m_run = 1'b0; m_own = 1'b0; m_last = 1'b1; m_unal = 1'b0; m_beats = 0;
    m_addr[0] = '0; m_addr[1] = '0; m_rem[0] = 0; m_rem[1] = 0;
    prev_g = 1'b0; prev_own = 1'b0; cur_len = 0; cur_start = -1; rx_takes_total = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_eq("R1", "gnt during reset", gnt_rx | gnt_tx, 0);
    chk_eq("R1", "bm_valid during reset", bm_valid, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk_eq("R1", "busy after reset", rx_busy | tx_busy, 0);
    chk_eq("R1", "takes after reset", rx_take | tx_put, 0);
    model_on = 1'b1;

    // R4 R6: both loaded together, limit 4 each; receive first after reset
    cfg_rx_cnt = 8'h81; cfg_tx_cnt = 8'h81; nb = 0;
    tick();
    rx_ld = 1'b1; rx_ld_addr = AW'(200); rx_ld_len = LW'(8);
    tx_ld = 1'b1; tx_ld_addr = AW'(300); tx_ld_len = LW'(8);
    tick();
    rx_ld = 1'b0; tx_ld = 1'b0;
    wait_idle();
    chk_eq("R6", "first owner after reset (0=rx)", bown[0], 0);
    chk_eq("R6", "second owner (1=tx)", bown[1], 1);
    chk_eq("R4", "burst 0 length", blen[0], 4);
    chk_eq("R4", "burst 1 length", blen[1], 4);
    chk_eq("R8", "burst 2 start", bstart[2], 204);
    chk_eq("R8", "burst 3 start", bstart[3], 304);

    // R5: limit armed but no contender
    nb = 0;
    load_one(1'b0, 40, 12);
    wait_idle();
    chk_eq("R5", "burst count", nb, 1);
    chk_eq("R5", "single burst length", blen[0], 12);

    // R9: write hand-over held to line end
    cfg_wr_align = 1'b1; cfg_line_words = 6'd8; nb = 0;
    tick();
    rx_ld = 1'b1; rx_ld_addr = AW'(2); rx_ld_len = LW'(20);
    tick();
    rx_ld = 1'b0; tx_ld = 1'b1; tx_ld_addr = AW'(500); tx_ld_len = LW'(8);
    tick();
    tx_ld = 1'b0;
    wait_idle();
    chk_eq("R9", "first write burst length", blen[0], 6);
    chk_eq("R9", "read burst after hand-over", blen[1], 4);
    chk_eq("R9", "write resumes on line", bstart[2], 8);
    chk_eq("R9", "second write burst length", blen[2], 8);
    cfg_wr_align = 1'b0;

    // R10: read start alignment
    cfg_rd_align = 1'b1; cfg_tx_cnt = 8'h00; nb = 0;
    load_one(1'b1, 3, 10);
    wait_idle();
    chk_eq("R10", "unaligned read burst length", blen[0], 5);
    chk_eq("R10", "next read start", bstart[1], 8);
    chk_eq("R10", "next read length", blen[1], 5);
    cfg_rd_align = 1'b0;

    // R7: disconnect on the third word
    cfg_rx_cnt = 8'h00; nb = 0;
    begin
      bit did;
      did = 1'b0;
      load_one(1'b0, 100, 6);
      for (int i = 0; i < 60; i++) begin
        tgt_stop = (gnt_rx && cur_len == 2 && !did);
        if (tgt_stop) did = 1'b1;
        tick();
        tgt_stop = 1'b0;
      end
    end
    wait_idle();
    chk_eq("R7", "disconnected burst length", blen[0], 3);
    chk_eq("R8", "resume address after disconnect", bstart[1], 103);
    chk_eq("R8", "resumed burst length", blen[1], 3);

    // R7: retry (stop without ready)
    nb = 0;
    load_one(1'b0, 150, 4);
    for (int i = 0; i < 20; i++) begin
      if (gnt_rx) begin
        tgt_ready = 1'b0; tgt_stop = 1'b1;
        tick();
        quiet_bus();
        break;
      end
      tick();
    end
    wait_idle();
    chk_eq("R7", "retried burst takes", blen[0], 0);
    chk_eq("R8", "retry resumes same address", bstart[1], 150);
    chk_eq("R8", "retry burst length", blen[1], 4);

    // R11: receive FIFO empties mid-burst
    nb = 0;
    load_one(1'b0, 700, 8);
    for (int i = 0; i < 20; i++) begin
      if (gnt_rx) break;
      tick();
    end
    tick(); tick();
    rx_empty = 1'b1;
    tick();
    rx_empty = 1'b0;
    wait_idle();
    chk_eq("R11", "burst cut by empty FIFO", blen[0], 2);
    chk_eq("R8", "start after empty", bstart[1], 702);

    // R2: load while busy is ignored
    nb = 0; rx_takes_total = 0;
    load_one(1'b0, 50, 6);
    for (int i = 0; i < 20; i++) begin
      if (gnt_rx) break;
      tick();
    end
    rx_ld = 1'b1; rx_ld_addr = AW'(900); rx_ld_len = LW'(3);
    tick();
    rx_ld = 1'b0;
    wait_idle();
    chk_eq("R2", "bursts with ignored load", nb, 1);
    chk_eq("R2", "words taken", rx_takes_total, 6);
    chk_eq("R2", "start address kept", bstart[0], 50);

    // random traffic against the model
    for (int ep = 0; ep < 12; ep++) begin
      int lsel;
      cfg_rx_cnt = {1'($urandom % 2), 7'($urandom % 4)};
      cfg_tx_cnt = {1'($urandom % 2), 7'($urandom % 4)};
      cfg_rd_align = 1'($urandom % 2);
      cfg_wr_align = 1'($urandom % 2);
      lsel = $urandom % 4;
      cfg_line_words = 6'(4 << lsel);
      for (int i = 0; i < 2000; i++) begin
        tgt_ready = ($urandom % 10) < 7;
        tgt_stop  = ($urandom % 12) == 0;
        rx_empty  = ($urandom % 7) == 0;
        tx_full   = ($urandom % 7) == 0;
        rx_ld = ($urandom % 20) == 0;
        rx_ld_addr = AW'($urandom % 4096);
        rx_ld_len = LW'(1 + $urandom % 40);
        tx_ld = ($urandom % 20) == 0;
        tx_ld_addr = AW'($urandom % 4096);
        tx_ld_len = LW'(1 + $urandom % 40);
        tick();
      end
      rx_ld = 1'b0; tx_ld = 1'b0;
      quiet_bus();
      wait_idle();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule